// File: doc/BRIEF.md
# Slave-Mode Trigger Counter

This block is a 16-bit counter whose advance is decided by a slave-mode controller. A three-bit mode input picks how the counter moves. It can run on every clock. It can count as a quadrature decoder on two channel inputs. It can restart on a trigger, advance only while a trigger is high, start on a trigger edge, or count trigger edges as an external clock. The trigger comes from a source-select register. That register picks one of four internal trigger lines, a pulse that fires on any transition of channel A, or the level of channel A or channel B.

The counter wraps between zero and an auto-reload value. It raises a one-cycle update pulse whenever it wraps in either direction and whenever a trigger restarts it. The channel inputs are assumed to be already synchronized and filtered. All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `tsc_slave_ctl`

## Requirements
- R1: The source-select register maps code 0..3 to internal trigger line 0..3, code 4 to the channel-A any-edge pulse, code 5 to the channel A level and code 6 to the channel B level. Code 7 gives a trigger that is always low.
- R2: With source code 4, every transition of channel A, rising or falling, counts as one trigger rising edge.
- R3: In mode 0, the counter steps up by one on every clock while `cnt_en_i` is high, and holds while it is low.
- R4: Modes 1, 2 and 3 count only while `cnt_en_i` is high. Mode 1 steps on each channel B edge. Mode 2 steps on each channel A edge. Mode 3 steps on an edge of either channel, but does not step when both change in the same cycle. An edge on A steps down when the new A equals B. An edge on B steps down when the new B differs from A. Otherwise the step is up.
- R5: `dir_o` is registered. It is 1 after a down step and 0 after an up step, holds between encoder steps, and is 0 in every non-encoder mode.
- R6: In mode 4, the counter steps as in mode 0. A trigger rising edge reloads it to 0 and pulses `update_o`, whether or not the counter is enabled.
- R7: In mode 5, the counter steps only while `cnt_en_i` and the trigger are both high. It holds its value, without clearing, while the trigger is low.
- R8: In mode 6, a trigger rising edge latches a start. The counter then steps every clock from the following cycle, even with `cnt_en_i` low and the trigger back low. The latch clears when the mode leaves 6.
- R9: In mode 7, each trigger rising edge steps the counter up by one while `cnt_en_i` is high.
- R10: Stepping up from a value at or above `arr_i` gives 0. Stepping down from 0 gives `arr_i`. Both wraps pulse `update_o` for one cycle, aligned with the new count.
- R11: Mode 5 with source code 4 is illegal. `cfg_err_o` is high while this combination holds, and the counter does not step.
- R12: A write to the source-select register takes effect only when `slave_mode_i` is 0 in the write cycle. A write in any other mode is ignored.
- R13: After reset, the count, `dir_o`, `update_o` and `cfg_err_o` are 0, and the source-select register holds code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Counter enable |
| slave_mode_i | input | 3 | Slave mode code 0..7 |
| src_wr_i | input | 1 | Write strobe for the source-select register |
| src_sel_i | input | 3 | Source code to write |
| int_trig_i | input | 4 | Internal trigger lines 0..3 |
| chan_a_i | input | 1 | Filtered channel A |
| chan_b_i | input | 1 | Filtered channel B |
| arr_i | input | 16 | Auto-reload value |
| count_o | output | 16 | Counter value |
| dir_o | output | 1 | Direction of the last step (1 = down) |
| update_o | output | 1 | One-cycle update event |
| cfg_err_o | output | 1 | Illegal gated/edge-source combination |

## Verification
The bench runs both quadrature directions across zero. A design with the direction rule inverted would count the wrong way, and one that forgot the underflow wrap would show 0xFFFF instead of the reload value. It toggles both channels in one cycle in mode 3 and expects no step, and it times the trigger-start latch so that a counter that starts in the trigger cycle, or stops when the trigger falls, is off by one. It writes the source select in a non-zero mode and expects the old source to stay in use. It drives the any-edge source in gated mode and expects the error flag with a frozen count, and it sends a restart trigger while the counter is disabled, which a reload gated by the enable would miss.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [2:0] {
    SM_FREE   = 3'd0,
    SM_QB     = 3'd1,
    SM_QA     = 3'd2,
    SM_QAB    = 3'd3,
    SM_RESTRT = 3'd4,
    SM_GATE   = 3'd5,
    SM_START  = 3'd6,
    SM_EXTCK  = 3'd7
  } slave_mode_e;

  typedef enum logic [2:0] {
    SRC_IT0  = 3'd0,
    SRC_IT1  = 3'd1,
    SRC_IT2  = 3'd2,
    SRC_IT3  = 3'd3,
    SRC_AEDG = 3'd4,
    SRC_ALVL = 3'd5,
    SRC_BLVL = 3'd6,
    SRC_NONE = 3'd7
  } trig_src_e;

  typedef struct packed {
    logic step;
    logic down;
    logic reload;
  } cnt_cmd_t;

endpackage

// File: rtl/tsc_trig_path.sv
module tsc_trig_path
  import tsc_pkg::*;
#(
  parameter int N_IT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_wr,
  input  logic [2:0]      src_d,
  input  logic            wr_open,
  input  logic [N_IT-1:0] int_trig,
  input  logic            chan_a,
  input  logic            chan_b,
  output logic [2:0]      src_q,
  output logic            a_edge,
  output logic            b_edge,
  output logic            trig_lvl,
  output logic            trig_rise
);

  logic            a_q;
  logic            b_q;
  logic            lvl_q;
  logic [N_IT-1:0] it_hit;
  logic            it_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_IT0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      if (src_wr && wr_open) src_q <= src_d;
      a_q   <= chan_a;
      b_q   <= chan_b;
      lvl_q <= trig_lvl;
    end
  end

  assign a_edge = chan_a ^ a_q;
  assign b_edge = chan_b ^ b_q;

  for (genvar g = 0; g < N_IT; g++) begin : g_it
    assign it_hit[g] = int_trig[g] && (src_q == 3'(g));
  end
  assign it_lvl = |it_hit;

  always_comb begin
    case (trig_src_e'(src_q))
      SRC_AEDG: trig_lvl = a_edge;
      SRC_ALVL: trig_lvl = chan_a;
      SRC_BLVL: trig_lvl = chan_b;
      SRC_NONE: trig_lvl = 1'b0;
      default:  trig_lvl = it_lvl;
    endcase
  end

  assign trig_rise = (src_q == SRC_AEDG) ? a_edge : (trig_lvl && !lvl_q);

endmodule

// File: rtl/tsc_mode_ctl.sv
module tsc_mode_ctl
  import tsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       cnt_en,
  input  logic [2:0] src_q,
  input  logic       trig_lvl,
  input  logic       trig_rise,
  input  logic       chan_a,
  input  logic       chan_b,
  input  logic       a_edge,
  input  logic       b_edge,
  output cnt_cmd_t   cmd,
  output logic       cfg_err,
  output logic       dir_q
);

  slave_mode_e md;
  logic        started_q;
  logic        dn_on_a;
  logic        dn_on_b;
  logic        enc_mode;

  assign md       = slave_mode_e'(mode);
  assign dn_on_a  = ~(chan_a ^ chan_b);
  assign dn_on_b  = chan_a ^ chan_b;
  assign enc_mode = (md == SM_QB) || (md == SM_QA) || (md == SM_QAB);

  always_comb begin
    cmd     = '0;
    cfg_err = 1'b0;
    case (md)
      SM_FREE: cmd.step = cnt_en;
      SM_QB: begin
        cmd.step = cnt_en && b_edge;
        cmd.down = dn_on_b;
      end
      SM_QA: begin
        cmd.step = cnt_en && a_edge;
        cmd.down = dn_on_a;
      end
      SM_QAB: begin
        cmd.step = cnt_en && (a_edge ^ b_edge);
        cmd.down = a_edge ? dn_on_a : dn_on_b;
      end
      SM_RESTRT: begin
        cmd.step   = cnt_en;
        cmd.reload = trig_rise;
      end
      SM_GATE: begin
        cfg_err  = (src_q == SRC_AEDG);
        cmd.step = cnt_en && trig_lvl && !cfg_err;
      end
      SM_START: cmd.step = cnt_en || started_q;
      SM_EXTCK: cmd.step = cnt_en && trig_rise;
      default:  cmd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      dir_q     <= 1'b0;
    end else begin
      if (md != SM_START) started_q <= 1'b0;
      else if (trig_rise) started_q <= 1'b1;
      if (!enc_mode)     dir_q <= 1'b0;
      else if (cmd.step) dir_q <= cmd.down;
    end
  end

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter
  import tsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_cmd_t         cmd,
  input  logic [CNT_W-1:0] arr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             upd_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else if (cmd.reload) begin
      cnt_q <= '0;
      upd_q <= 1'b1;
    end else if (cmd.step && cmd.down) begin
      if (cnt_q == '0) begin
        cnt_q <= arr;
        upd_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - ONE;
        upd_q <= 1'b0;
      end
    end else if (cmd.step) begin
      if (cnt_q >= arr) begin
        cnt_q <= '0;
        upd_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ONE;
        upd_q <= 1'b0;
      end
    end else begin
      upd_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tsc_slave_ctl.sv
module tsc_slave_ctl
  import tsc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_IT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_i,
  input  logic [2:0]       slave_mode_i,
  input  logic             src_wr_i,
  input  logic [2:0]       src_sel_i,
  input  logic [N_IT-1:0]  int_trig_i,
  input  logic             chan_a_i,
  input  logic             chan_b_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             update_o,
  output logic             cfg_err_o
);

  logic [2:0] src_q;
  logic       a_edge;
  logic       b_edge;
  logic       trig_lvl;
  logic       trig_rise;
  cnt_cmd_t   cmd;

  tsc_trig_path #(.N_IT(N_IT)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_wr    (src_wr_i),
    .src_d     (src_sel_i),
    .wr_open   (slave_mode_i == SM_FREE),
    .int_trig  (int_trig_i),
    .chan_a    (chan_a_i),
    .chan_b    (chan_b_i),
    .src_q     (src_q),
    .a_edge    (a_edge),
    .b_edge    (b_edge),
    .trig_lvl  (trig_lvl),
    .trig_rise (trig_rise)
  );

  tsc_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (slave_mode_i),
    .cnt_en    (cnt_en_i),
    .src_q     (src_q),
    .trig_lvl  (trig_lvl),
    .trig_rise (trig_rise),
    .chan_a    (chan_a_i),
    .chan_b    (chan_b_i),
    .a_edge    (a_edge),
    .b_edge    (b_edge),
    .cmd       (cmd),
    .cfg_err   (cfg_err_o),
    .dir_q     (dir_o)
  );

  tsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .arr   (arr_i),
    .cnt_q (count_o),
    .upd_q (update_o)
  );

endmodule

// File: rtl/tsc_slave_ctl_chk.sv
module tsc_slave_ctl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en_i,
  input logic [2:0]       slave_mode_i,
  input logic             src_wr_i,
  input logic [CNT_W-1:0] arr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_o,
  input logic             update_o,
  input logic             cfg_err_o,
  input logic [2:0]       src_q,
  input logic             trig_lvl
);

  // R11
  err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> $stable(count_o));

  // R10
  upd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> (count_o == '0 || count_o == $past(arr_i)));

  // R3
  free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode_i == 3'd0 && cnt_en_i && count_o < arr_i)
      |=> (count_o == $past(count_o) + CNT_W'(1)));

  // R12
  src_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode_i != 3'd0 || !src_wr_i) |=> $stable(src_q));

  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode_i == 3'd5 && !trig_lvl) |=> $stable(count_o));

  // R5
  dir_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode_i == 3'd0 || slave_mode_i[2]) |=> !dir_o);

endmodule

bind tsc_slave_ctl tsc_slave_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_en_i     (cnt_en_i),
  .slave_mode_i (slave_mode_i),
  .src_wr_i     (src_wr_i),
  .arr_i        (arr_i),
  .count_o      (count_o),
  .dir_o        (dir_o),
  .update_o     (update_o),
  .cfg_err_o    (cfg_err_o),
  .src_q        (src_q),
  .trig_lvl     (trig_lvl)
);

// File: tb/tsc_slave_ctl_bench.sv
`timescale 1ns/1ps
module tsc_slave_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en_i = 1'b0;
  logic [2:0]  slave_mode_i = 3'd0;
  logic        src_wr_i = 1'b0;
  logic [2:0]  src_sel_i = 3'd0;
  logic [3:0]  int_trig_i = 4'd0;
  logic        chan_a_i = 1'b0;
  logic        chan_b_i = 1'b0;
  logic [15:0] arr_i = 16'd5;
  logic [15:0] count_o;
  logic        dir_o;
  logic        update_o;
  logic        cfg_err_o;

  always #4 clk = ~clk;

  tsc_slave_ctl u_tsc_slave_ctl (
    .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .slave_mode_i(slave_mode_i),
    .src_wr_i(src_wr_i), .src_sel_i(src_sel_i), .int_trig_i(int_trig_i),
    .chan_a_i(chan_a_i), .chan_b_i(chan_b_i), .arr_i(arr_i),
    .count_o(count_o), .dir_o(dir_o), .update_o(update_o), .cfg_err_o(cfg_err_o)
  );

  typedef struct packed {
    logic [15:0] cnt;
    logic        dir;
    logic        upd;
    logic        err;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  logic [15:0] m_cnt = 0;
  logic        m_dir = 0, m_a = 0, m_b = 0, m_lvl = 0, m_run = 0;
  logic [2:0]  m_src = 0;

  task automatic drive(input logic en, input logic [2:0] md, input logic wr,
                       input logic [2:0] sel, input logic [3:0] it,
                       input logic a, input logic b, input string tag);
    logic ea, eb, lvl, rise, stp, dn, rld, erold, upd;
    exp_t e;
    @(negedge clk);
    cnt_en_i = en; slave_mode_i = md; src_wr_i = wr; src_sel_i = sel;
    int_trig_i = it; chan_a_i = a; chan_b_i = b;
    ea = a ^ m_a; eb = b ^ m_b;
    case (m_src)
      3'd4: lvl = ea;
      3'd5: lvl = a;
      3'd6: lvl = b;
      3'd7: lvl = 1'b0;
      default: lvl = it[m_src[1:0]];
    endcase
    rise = (m_src == 3'd4) ? ea : (lvl && !m_lvl);
    erold = (md == 3'd5) && (m_src == 3'd4);
    stp = 0; dn = 0; rld = 0;
    case (md)
      3'd0: stp = en;
      3'd1: begin stp = en && eb; dn = a ^ b; end
      3'd2: begin stp = en && ea; dn = (a == b); end
      3'd3: begin stp = en && (ea != eb); dn = ea ? (a == b) : (a ^ b); end
      3'd4: begin stp = en; rld = rise; end
      3'd5: stp = en && lvl && !erold;
      3'd6: stp = en || m_run;
      default: stp = en && rise;
    endcase
    upd = 0;
    if (rld) begin m_cnt = 0; upd = 1; end
    else if (stp && dn) begin
      if (m_cnt == 0) begin m_cnt = arr_i; upd = 1; end else m_cnt = m_cnt - 1;
    end else if (stp) begin
      if (m_cnt >= arr_i) begin m_cnt = 0; upd = 1; end else m_cnt = m_cnt + 1;
    end
    if (md == 3'd1 || md == 3'd2 || md == 3'd3) begin
      if (stp) m_dir = dn;
    end else m_dir = 0;
    if (md != 3'd6) m_run = 0; else if (rise) m_run = 1;
    if (wr && md == 3'd0) m_src = sel;
    m_a = a; m_b = b; m_lvl = lvl;
    e.cnt = m_cnt; e.dir = m_dir; e.upd = upd;
    e.err = (md == 3'd5) && (m_src == 3'd4);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (expq.size() > 0) begin : mon
      exp_t  e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      n_chk++;
      if (count_o !== e.cnt || dir_o !== e.dir || update_o !== e.upd || cfg_err_o !== e.err) begin
        n_fail++;
        $display("FAIL %s: cnt=%0d dir=%0b upd=%0b err=%0b, expected cnt=%0d dir=%0b upd=%0b err=%0b",
                 t, count_o, dir_o, update_o, cfg_err_o, e.cnt, e.dir, e.upd, e.err);
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count_o == 0, "R13 count", count_o, 0);
    chk(dir_o == 0, "R13 dir", dir_o, 0);
    chk(update_o == 0, "R13 update", update_o, 0);
    chk(cfg_err_o == 0, "R13 err", cfg_err_o, 0);

    for (int i = 0; i < 8; i++) drive(1, 0, 0, 0, 0, 0, 0, "R3/R10 free run wrap");
    for (int i = 0; i < 2; i++) drive(0, 0, 0, 0, 0, 0, 0, "R3 hold");

    drive(0, 0, 1, 3'd5, 0, 0, 0, "R12 write src A level");
    drive(1, 7, 0, 0, 0, 1, 0, "R9 ext clock");
    drive(1, 7, 0, 0, 0, 1, 0, "R9 ext clock");
    drive(1, 7, 0, 0, 0, 0, 0, "R9 ext clock");
    drive(1, 7, 0, 0, 0, 1, 0, "R9 ext clock");
    drive(1, 7, 1, 3'd6, 0, 1, 0, "R12 ignored write");
    drive(1, 7, 0, 0, 0, 1, 1, "R12 old source kept");
    drive(1, 7, 0, 0, 0, 1, 0, "R12 old source kept");
    drive(1, 7, 0, 0, 0, 0, 0, "R12 old source kept");
    drive(1, 7, 0, 0, 0, 1, 0, "R12 old source kept");

    drive(0, 0, 1, 3'd4, 0, 1, 0, "R2 write edge source");
    drive(1, 7, 0, 0, 0, 0, 0, "R2 falling edge counts");
    drive(1, 7, 0, 0, 0, 0, 0, "R2 no edge");
    drive(1, 7, 0, 0, 0, 1, 0, "R2 rising edge counts");
    drive(1, 7, 0, 0, 0, 1, 0, "R2 no edge");
    drive(1, 7, 0, 0, 0, 0, 0, "R2 falling edge counts");

    drive(1, 5, 0, 0, 4'hF, 1, 0, "R11 illegal gate");
    drive(1, 5, 0, 0, 4'hF, 0, 0, "R11 illegal gate");
    drive(1, 5, 0, 0, 4'hF, 1, 0, "R11 illegal gate");

    drive(0, 0, 1, 3'd0, 0, 0, 0, "R1 select line 0");
    drive(1, 5, 0, 0, 4'h1, 0, 0, "R7 gate high");
    drive(1, 5, 0, 0, 4'h1, 0, 0, "R7 gate high");
    drive(1, 5, 0, 0, 4'h0, 0, 0, "R7 gate low hold");
    drive(1, 5, 0, 0, 4'hE, 0, 0, "R7 gate low hold");
    drive(1, 5, 0, 0, 4'h1, 0, 0, "R7 gate high");

    drive(1, 4, 0, 0, 4'h0, 0, 0, "R6 restart mode run");
    drive(1, 4, 0, 0, 4'h0, 0, 0, "R6 restart mode run");
    drive(1, 4, 0, 0, 4'h1, 0, 0, "R6 trigger reload");
    drive(1, 4, 0, 0, 4'h1, 0, 0, "R6 run after reload");
    drive(1, 4, 0, 0, 4'h0, 0, 0, "R6 run");
    drive(0, 4, 0, 0, 4'h1, 0, 0, "R6 reload while disabled");
    drive(0, 4, 0, 0, 4'h1, 0, 0, "R6 disabled hold");

    drive(0, 0, 1, 3'd3, 0, 0, 0, "R1 select line 3");
    drive(1, 7, 0, 0, 4'h1, 0, 0, "R1 line 0 ignored");
    drive(1, 7, 0, 0, 4'h0, 0, 0, "R1 line 0 ignored");
    drive(1, 7, 0, 0, 4'h8, 0, 0, "R1 line 3 counts");
    drive(1, 7, 0, 0, 4'h0, 0, 0, "R1 line 3 low");

    drive(0, 6, 0, 0, 4'h0, 0, 0, "R8 waits");
    drive(0, 6, 0, 0, 4'h0, 0, 0, "R8 waits");
    drive(0, 6, 0, 0, 4'h8, 0, 0, "R8 trigger latched");
    drive(0, 6, 0, 0, 4'h0, 0, 0, "R8 runs after trigger");
    drive(0, 6, 0, 0, 4'h0, 0, 0, "R8 runs after trigger");
    drive(0, 6, 0, 0, 4'h0, 0, 0, "R8 runs after trigger");
    drive(0, 0, 0, 0, 4'h0, 0, 0, "R8 latch cleared");
    drive(0, 0, 0, 0, 4'h0, 0, 0, "R8 latch cleared");

    drive(1, 0, 0, 0, 0, 0, 0, "R3 to 1");
    drive(1, 3, 0, 0, 0, 1, 0, "R4 fwd A rise");
    drive(1, 3, 0, 0, 0, 1, 1, "R4 fwd B rise");
    drive(1, 3, 0, 0, 0, 0, 1, "R4 fwd A fall");
    drive(1, 3, 0, 0, 0, 0, 0, "R4 fwd B fall");
    for (int k = 0; k < 2; k++) begin
      drive(1, 3, 0, 0, 0, 0, 1, "R4/R5 rev B rise");
      drive(1, 3, 0, 0, 0, 1, 1, "R4/R5 rev A rise");
      drive(1, 3, 0, 0, 0, 1, 0, "R4/R10 rev B fall");
      drive(1, 3, 0, 0, 0, 0, 0, "R4/R10 rev A fall");
    end
    drive(1, 3, 0, 0, 0, 1, 1, "R4 both change no step");
    drive(1, 3, 0, 0, 0, 1, 1, "R5 dir held");
    drive(1, 1, 0, 0, 0, 0, 1, "R4 mode1 A edge ignored");
    drive(1, 1, 0, 0, 0, 0, 0, "R4 mode1 B edge");
    drive(1, 1, 0, 0, 0, 1, 0, "R4 mode1 A edge ignored");
    drive(1, 1, 0, 0, 0, 1, 1, "R4 mode1 B edge");
    drive(1, 2, 0, 0, 0, 0, 1, "R4 mode2 A edge");
    drive(1, 2, 0, 0, 0, 0, 0, "R4 mode2 B edge ignored");
    drive(1, 2, 0, 0, 0, 1, 0, "R4 mode2 A edge");
    drive(1, 2, 0, 0, 0, 1, 1, "R4 mode2 B edge ignored");
    drive(0, 2, 0, 0, 0, 0, 1, "R4 disabled no step");
    drive(1, 0, 0, 0, 0, 0, 1, "R5 dir cleared");
    drive(0, 0, 0, 0, 0, 0, 1, "R5 idle");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule